// File: doc/BRIEF.md
# Ramp-Tracking Time Base Synchronizer

This block keeps two phase-accumulator time bases, both living in one fast system clock domain, in step with each other. The reference ramp advances by exactly one unit whenever its clock-enable strobe pulses. That normalizes elapsed time to the reference sample period. The tracked ramp advances by a variable step whenever its own strobe pulses. A second-order digital loop adjusts that step until both ramps climb at the same slope.

Each tracked update takes the signed difference between the reference ramp and the tracked ramp as the phase error. The error feeds two paths. A proportional path applies the error at once to the step being added. An integral path accumulates the error into a step register, and that register ends up holding the learned ratio of the tracked clock's period to the reference clock's period. Both gains are programmable right shifts, so no multipliers are needed. Small gains keep steady-state step jitter very low. A lock flag reports sustained small error.

A downstream basepoint and fractional-interval generator uses the ramps and the step estimate to place interpolants. Clock generation, cross-domain buffering and the interpolator are outside this block.

Top module: `ramp_sync`

## Requirements
- R1: Reset is asynchronous and active low. Its release takes effect two clock edges later. Up to that point both ramps read 0, `locked` reads 0, and every edge loads `step_est` from `step_init`.
- R2: `ref_ramp` is unsigned fixed point with 16 integer and 24 fractional bits, so one unit is 2^24. It grows by exactly 2^24 on each cycle with `ref_tick` high, holds otherwise, and wraps modulo 2^40.
- R3: On each cycle with `trk_tick` high, `trk_ramp` grows by an effective step and wraps modulo 2^40. The effective step is `step_est + (err >>> kp_shift)`, floored at 0 and capped at 2^40-1. `trk_ramp` holds on all other cycles.
- R4: The phase error `err` is `ref_ramp - trk_ramp` taken as a 40-bit two's complement value, so a common wrap of both ramps cancels. A non-negative error never lowers `step_est`.
- R5: On each cycle with `trk_tick` high, `step_est` becomes `step_est + (err >>> ki_shift)`, clamped to the range 0 to 2^40-1. It holds on all other cycles.
- R6: Use `ref_tick` once every 3 cycles, `trk_tick` every cycle, `kp_shift`=4, `ki_shift`=10 and a starting step of 0.25. After 20000 cycles `step_est` lies within 1% of 1/3 (5592405).
- R7: `locked` rises at the edge of the 256th consecutive `trk_tick` update on which |err| < `lock_thresh`. Cycles with no tick and an in-band error neither count nor break the run.
- R8: After any cycle in which |err| >= `lock_thresh`, `locked` is 0 and the run count restarts from zero. This holds whether or not a strobe pulses in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference-rate clock enable |
| trk_tick | input | 1 | Tracked-rate clock enable; also paces loop updates |
| kp_shift | input | 5 | Proportional gain as a right-shift count |
| ki_shift | input | 5 | Integral gain as a right-shift count |
| step_init | input | 40 | Initial step guess, Q16.24 |
| lock_thresh | input | 40 | Error magnitude bound for lock, Q16.24 |
| ref_ramp | output | 40 | Reference time base, Q16.24 |
| trk_ramp | output | 40 | Tracked time base, Q16.24 |
| step_est | output | 40 | Integrated step estimate, Q16.24 |
| locked | output | 1 | Lock indication |

## Verification
Some properties hold every cycle, and the embedded assertions check those. Each ramp and the step register stay frozen when no strobe or reset load is present. A non-negative error never reduces the step. Any out-of-band error clears `locked` on the next edge. A rise of `locked` always follows a tracked update. The bench scenarios are needed for everything arithmetic or long-range: exact ramp and step values under several strobe ratios and gain settings, the floor and the cap on the step, cancellation across a full 40-bit wrap, convergence to the 1/3 ratio, and the exact 256-update lock delay after the run restarts.

// File: rtl/ramp_sync_pkg.sv
package ramp_sync_pkg;
  localparam int SHIFT_W = 5;

  typedef logic [SHIFT_W-1:0] shift_t;

  // Loop gains expressed as arithmetic right-shift counts
  typedef struct packed {
    shift_t prop;
    shift_t integ;
  } loop_gain_t;
endpackage

// File: rtl/ramp_sync_accum.sv
module ramp_sync_accum #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         init,
  input  logic         tick,
  input  logic [W-1:0] step,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (init)      q_nxt = '0;
    else if (tick) q_nxt = q_r + step;   // modulo 2^W wrap
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q_r <= '0;
    else         q_r <= q_nxt;
  end

  assign q = q_r;

  // R2 / R3: a ramp only moves on its own strobe
  assert_ramp_hold_R2: assert property (@(posedge clk) disable iff (!arst_n)
    (!init && !tick) |=> $stable(q_r));
endmodule

// File: rtl/ramp_sync_loop.sv
module ramp_sync_loop
  import ramp_sync_pkg::*;
#(
  parameter int W = 40
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                init,
  input  logic                tick,
  input  logic signed [W-1:0] err,
  input  loop_gain_t          gains,
  input  logic [W-1:0]        step_init,
  output logic [W-1:0]        step_est,
  output logic [W-1:0]        step_eff
);
  localparam int EW = W + 2;

  logic [W-1:0]         integ_r, integ_nxt;
  logic signed [W-1:0]  p_term, i_term;
  logic signed [EW-1:0] p_sum, i_sum;

  // Saturate an extended signed sum into the unsigned range [0, 2^W-1]
  function automatic logic [W-1:0] clamp_u(input logic signed [EW-1:0] s);
    if (s[EW-1])    return '0;
    else if (s[W])  return '1;
    else            return s[W-1:0];
  endfunction

  always_comb begin
    p_term = err >>> gains.prop;
    i_term = err >>> gains.integ;
    p_sum  = $signed({2'b00, integ_r}) + $signed({{2{p_term[W-1]}}, p_term});
    i_sum  = $signed({2'b00, integ_r}) + $signed({{2{i_term[W-1]}}, i_term});
    step_eff = clamp_u(p_sum);
    integ_nxt = integ_r;
    if (init)      integ_nxt = step_init;
    else if (tick) integ_nxt = clamp_u(i_sum);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) integ_r <= '0;
    else         integ_r <= integ_nxt;
  end

  assign step_est = integ_r;

  // R5: the learned step only changes on a tracked update or a reset load
  assert_step_hold_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (!init && !tick) |=> $stable(integ_r));
endmodule

// File: rtl/ramp_sync_lock.sv
module ramp_sync_lock #(
  parameter int W        = 40,
  parameter int LOCK_RUN = 256
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                init,
  input  logic                tick,
  input  logic signed [W-1:0] err,
  input  logic [W-1:0]        thresh,
  output logic                locked
);
  localparam int CW = $clog2(LOCK_RUN + 1);
  localparam logic [CW-1:0] RUN_FULL = CW'(LOCK_RUN);
  localparam logic [CW-1:0] RUN_LAST = CW'(LOCK_RUN - 1);

  logic [W-1:0]  mag;
  logic          in_band;
  logic [CW-1:0] run_r, run_nxt;
  logic          lk_r, lk_nxt;

  always_comb begin
    mag     = err[W-1] ? W'(-err) : W'(err);
    in_band = (mag < thresh);
    run_nxt = run_r;
    lk_nxt  = lk_r;
    if (init || !in_band) begin
      run_nxt = '0;
      lk_nxt  = 1'b0;
    end else if (tick) begin
      if (run_r != RUN_FULL) run_nxt = run_r + 1'b1;
      if (run_r == RUN_LAST) lk_nxt  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_r <= '0;
      lk_r  <= 1'b0;
    end else begin
      run_r <= run_nxt;
      lk_r  <= lk_nxt;
    end
  end

  assign locked = lk_r;

  // R7: lock is only ever gained on a tracked update
  assert_lock_on_update_R7: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(lk_r) |-> $past(tick));
endmodule

// File: rtl/ramp_sync.sv
module ramp_sync
  import ramp_sync_pkg::*;
#(
  parameter int INT_W    = 16,
  parameter int FRAC_W   = 24,
  parameter int LOCK_RUN = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ref_tick,
  input  logic                      trk_tick,
  input  logic [SHIFT_W-1:0]        kp_shift,
  input  logic [SHIFT_W-1:0]        ki_shift,
  input  logic [INT_W+FRAC_W-1:0]   step_init,
  input  logic [INT_W+FRAC_W-1:0]   lock_thresh,
  output logic [INT_W+FRAC_W-1:0]   ref_ramp,
  output logic [INT_W+FRAC_W-1:0]   trk_ramp,
  output logic [INT_W+FRAC_W-1:0]   step_est,
  output logic                      locked
);
  localparam int W = INT_W + FRAC_W;
  localparam logic [W-1:0] UNIT = W'(1) << FRAC_W;

  // Reset release synchronizer: internal init window spans two edges
  logic [1:0] rst_pipe;
  logic       init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign init = !rst_pipe[1];

  logic signed [W-1:0] err;
  logic [W-1:0]        step_eff;
  loop_gain_t          gains;

  assign gains = '{prop: kp_shift, integ: ki_shift};
  assign err   = $signed(ref_ramp - trk_ramp);

  ramp_sync_accum #(.W(W)) i_ref_ramp (
    .clk(clk), .arst_n(rst_n), .init(init), .tick(ref_tick),
    .step(UNIT), .q(ref_ramp)
  );

  ramp_sync_accum #(.W(W)) i_trk_ramp (
    .clk(clk), .arst_n(rst_n), .init(init), .tick(trk_tick),
    .step(step_eff), .q(trk_ramp)
  );

  ramp_sync_loop #(.W(W)) i_loop (
    .clk(clk), .arst_n(rst_n), .init(init), .tick(trk_tick),
    .err(err), .gains(gains), .step_init(step_init),
    .step_est(step_est), .step_eff(step_eff)
  );

  ramp_sync_lock #(.W(W), .LOCK_RUN(LOCK_RUN)) i_lock (
    .clk(clk), .arst_n(rst_n), .init(init), .tick(trk_tick),
    .err(err), .thresh(lock_thresh), .locked(locked)
  );

  // Checker-side magnitude, computed apart from the lock detector
  logic [W-1:0] chk_mag;
  assign chk_mag = err[W-1] ? (trk_ramp - ref_ramp) : (ref_ramp - trk_ramp);

  // R4: a non-negative error never pulls the step estimate down
  assert_pos_err_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && trk_tick && !err[W-1]) |=> (step_est >= $past(step_est)));

  // R8: an out-of-band error clears lock at the next edge
  assert_unlock_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_mag >= lock_thresh) |=> !locked);

  // R1: nothing is held as locked during the reset-release window
  assert_init_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> !locked);
endmodule

// File: tb/test_ramp_sync.sv
`timescale 1ns/1ps
module test_ramp_sync;
  localparam int W = 40;
  localparam logic [W-1:0] ONE = 40'h0001000000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ref_tick, trk_tick;
  logic [4:0]   kp_shift, ki_shift;
  logic [W-1:0] step_init, lock_thresh;
  logic [W-1:0] ref_ramp, trk_ramp, step_est;
  logic         locked;

  int tests = 0;
  int fails = 0;
  int phase = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  ramp_sync i_ramp_sync (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .trk_tick(trk_tick),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .step_init(step_init),
    .lock_thresh(lock_thresh), .ref_ramp(ref_ramp), .trk_ramp(trk_ramp),
    .step_est(step_est), .locked(locked)
  );

  // Behavioural expectation built from the requirements
  logic [W-1:0] m_ref, m_trk, m_step;
  logic         m_lock;
  int           m_run;

  function automatic logic [W-1:0] sat_add(input logic [W-1:0] b, input logic signed [W-1:0] d);
    logic signed [W+1:0] s;
    s = $signed({2'b00, b}) + $signed({{2{d[W-1]}}, d});
    if (s < 0) return '0;
    if (s > $signed({2'b00, {W{1'b1}}})) return '1;
    return s[W-1:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ref <= '0; m_trk <= '0; m_step <= step_init; m_lock <= 1'b0; m_run <= 0;
    end else begin
      logic signed [W-1:0] e;
      logic [W-1:0] a;
      e = $signed(m_ref - m_trk);
      a = e[W-1] ? (m_trk - m_ref) : (m_ref - m_trk);
      if (ref_tick) m_ref <= m_ref + ONE;
      if (trk_tick) begin
        m_trk  <= m_trk + sat_add(m_step, e >>> kp_shift);
        m_step <= sat_add(m_step, e >>> ki_shift);
      end
      if (a >= lock_thresh) begin
        m_run <= 0; m_lock <= 1'b0;
      end else if (trk_tick) begin
        if (m_run < 256) m_run <= m_run + 1;
        if (m_run == 255) m_lock <= 1'b1;
      end
    end
  end

  task automatic check(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit           bad;
  logic [63:0]  bad_act, bad_exp;

  // Ticks follow a free-running phase; rp or tp of 0 means never
  task automatic run(input int n, input int rp, input int tp, input bit cmp);
    for (int i = 0; i < n; i++) begin
      ref_tick = (rp > 0) && (phase % rp == 0);
      trk_tick = (tp > 0) && (phase % tp == 0);
      phase++;
      @(negedge clk);
      if (cmp && !bad && (ref_ramp !== m_ref || trk_ramp !== m_trk ||
                          step_est !== m_step || locked !== m_lock)) begin
        bad = 1;
        bad_act = {trk_ramp[31:0], step_est[31:0]};
        bad_exp = {m_trk[31:0], m_step[31:0]};
      end
    end
    ref_tick = 0;
    trk_tick = 0;
  endtask

  task automatic do_reset(input logic [W-1:0] init_v, input logic [4:0] kp, input logic [4:0] ki,
                          input logic [W-1:0] thr);
    @(negedge clk);
    ref_tick = 0; trk_tick = 0;
    kp_shift = kp; ki_shift = ki; step_init = init_v; lock_thresh = thr;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    phase = 0;
    bad = 0;
  endtask

  localparam logic [W-1:0] V_INIT [6] = '{40'h0001000000, 40'h0000400000, 40'h0001800000,
                                          40'h0000000000, 40'hFFF0000000, 40'h0001000000};
  localparam logic [W-1:0] V_THR  [6] = '{40'h0000100000, 40'h0001000000, 40'h0001000000,
                                          40'h0000800000, 40'hFFFFFFFFFF, 40'h0001000000};
  localparam int V_KP  [6] = '{31, 2, 3, 0, 31, 1};
  localparam int V_KI  [6] = '{31, 6, 8, 0, 31, 5};
  localparam int V_RP  [6] = '{1, 3, 2, 5, 1, 4};
  localparam int V_TP  [6] = '{1, 1, 3, 2, 1, 4};
  localparam int V_CYC [6] = '{300, 600, 800, 200, 100, 400};

  initial begin
    #950000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ref_tick = 0; trk_tick = 0; kp_shift = 0; ki_shift = 0;
    step_init = '0; lock_thresh = '0;

    // Vector table: cycle-by-cycle agreement with the expected ramps, step and lock (R2 R3 R4 R5 R7)
    for (int v = 0; v < 6; v++) begin
      do_reset(V_INIT[v], 5'(V_KP[v]), 5'(V_KI[v]), V_THR[v]);
      run(V_CYC[v], V_RP[v], V_TP[v], 1);
      check($sformatf("R2 R3 R4 R5 R7 vector %0d", v), !bad, bad_act, bad_exp);
    end

    // R1: reset state
    do_reset(40'h0000ABCDEF, 4, 10, ONE);
    check("R1 ref_ramp", ref_ramp == 0, ref_ramp, 0);
    check("R1 trk_ramp", trk_ramp == 0, trk_ramp, 0);
    check("R1 step_est", step_est == 40'h0000ABCDEF, step_est, 40'h0000ABCDEF);
    check("R1 locked", locked == 0, locked, 0);

    // R2 R5 R7: no strobes means nothing moves and no lock is gained
    run(300, 0, 0, 0);
    check("R2 ref hold", ref_ramp == 0, ref_ramp, 0);
    check("R5 step hold", step_est == 40'h0000ABCDEF, step_est, 40'h0000ABCDEF);
    check("R7 no update no lock", locked == 0, locked, 0);

    // R6: convergence to a one-third step
    do_reset(40'h0000400000, 4, 10, ONE);
    run(20000, 3, 1, 0);
    begin
      longint d;
      d = longint'(step_est) - 64'd5592405;
      if (d < 0) d = -d;
      check("R6 step near 1/3", d < 55924, step_est, 64'd5592405);
    end
    check("R7 locked after settling", locked == 1, locked, 1);

    // R8: zero threshold drops lock at once; R7: run restarts from zero
    lock_thresh = '0;
    run(1, 3, 1, 0);
    check("R8 lock dropped", locked == 0, locked, 0);
    lock_thresh = ONE;
    run(100, 3, 1, 0);
    check("R7 relock not early", locked == 0, locked, 0);
    run(300, 3, 1, 0);
    check("R7 relock", locked == 1, locked, 1);

    // R3 R5: step floors at zero, tracked ramp then freezes at 2.0
    do_reset(40'h0002000000, 0, 0, ONE);
    run(10, 0, 1, 0);
    check("R5 step floor", step_est == 0, step_est, 0);
    check("R3 trk frozen", trk_ramp == 40'h0002000000, trk_ramp, 40'h0002000000);

    // R4: identical ramps across a full wrap keep zero error
    do_reset(ONE, 0, 0, 40'h0000000001);
    run(65541, 1, 1, 0);
    check("R2 ref wrap", ref_ramp == 40'h0005000000, ref_ramp, 40'h0005000000);
    check("R3 trk wrap", trk_ramp == 40'h0005000000, trk_ramp, 40'h0005000000);
    check("R4 step unchanged", step_est == ONE, step_est, ONE);
    check("R4 lock kept over wrap", locked == 1, locked, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule